// File: doc/BRIEF.md
# Configurable pad pin multiplexer

This block routes a set of I/O pads between several on-chip signal functions. Each pad has three core signals: the value coming in from the pad, the value going out, and an output-enable. Input-enable is simply the inverse of output-enable. A 2-bit selection field per pad chooses which of four function slots owns the pad. Slot 0 is a general-purpose line tied 1:1 to its pad, with a per-pad direction bit. Slot 1 is a shared bidirectional bus function that drives its own output-enable. Slot 2 is an output-only function whose pads always drive. Slot 3 is an input-only function whose pads never drive.

The path back into the functions is not a mirror of the output mux. Every input-capable function line takes its value from a priority mux over all pads that currently select it, and the lowest-numbered pad wins. The input side decodes the same selection value as the output side, so one register setting serves both directions of the bus function. A general-purpose input is a single AND gate, because that line only ever maps to its own pad. The output-only function has no input logic at all.

Configuration is held in registers behind a simple synchronous write port with a combinational read port. Software sets up each pad's ownership and direction through these registers.

Top module: `pinmux_top`

## Requirements
- R1: After reset every selection field is 0 (general-purpose) and every direction bit is 0 (input). All pad output-enables are then low and every mapped register reads 0.
- R2: A write with wrEn high takes effect at the clock edge. Word address a below SEL_WORDS holds the selection fields of pads a*4 to a*4+3, two bits per pad, with pad a*4+i in bits [2i+1:2i]. Address SEL_WORDS (2 by default) holds the direction bits, with pad p in bit p and 1 meaning output. rdData returns the addressed word combinationally.
- R3: Writes with wrEn low change nothing. Writes to an unmapped address (3 by default) change nothing, and an unmapped address reads 0.
- R4: A pad with selection 0 outputs gpioOut[p], and its output-enable equals its direction bit.
- R5: gpioIn[p] equals padIn[p] when pad p has selection 0, and is 0 otherwise.
- R6: A pad p with selection 1 outputs busOut[p mod NUM_BUS], and its output-enable is busOe[p mod NUM_BUS].
- R7: A pad p with selection 2 outputs emitOut[p mod NUM_EMIT], and its output-enable is 1.
- R8: A pad with selection 3 has output 0 and output-enable 0.
- R9: busIn[k] equals padIn of the lowest-numbered pad p with selection 1 and p mod NUM_BUS = k. It is 0 when no pad qualifies.
- R10: captIn[k] equals padIn of the lowest-numbered pad p with selection 3 and p mod NUM_CAPT = k. It is 0 when no pad qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write word address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | ADDR_W | Register read word address |
| rdData | output | DATA_W | Register read data |
| padIn | input | NUM_PADS | Values arriving from the pads |
| padOut | output | NUM_PADS | Values driven to the pads |
| padOe | output | NUM_PADS | Pad output-enables (1 = drive) |
| gpioOut | input | NUM_PADS | General-purpose output values, one per pad |
| gpioIn | output | NUM_PADS | General-purpose input values, one per pad |
| busOut | input | NUM_BUS | Bus function output values |
| busOe | input | NUM_BUS | Bus function direction controls |
| busIn | output | NUM_BUS | Bus function input values |
| emitOut | input | NUM_EMIT | Output-only function values |
| captIn | output | NUM_CAPT | Input-only function values |

## Verification
Uniform configurations, with every pad on one slot, test each output and input path in isolation. Alternating data and enable patterns catch swapped lines or a wrong modulo mapping. Sparse configurations, with two pads on the same input line, tell the lowest-pad priority apart from a plain OR or highest-pad choice, and show that a line with no owner reads 0. Random configurations compared against a reference model catch mixed-slot interactions, including stale selections leaking onto the general-purpose inputs.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    FN_GPIO = 2'd0,
    FN_BUS  = 2'd1,
    FN_EMIT = 2'd2,
    FN_CAPT = 2'd3
  } fnSel_e;

  // Per-pad configuration handed from control to datapath
  typedef struct packed {
    fnSel_e sel;
    logic   gpioDir;
  } padCfg_t;
endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output padCfg_t           cfg [NUM_PADS]
);
  localparam int FPW       = DATA_W / SEL_W;
  localparam int SEL_WORDS = (NUM_PADS + FPW - 1) / FPW;

  logic [SEL_W-1:0]    selQ [NUM_PADS];
  logic [NUM_PADS-1:0] dirQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PADS; p++) selQ[p] <= '0;
      dirQ <= '0;
    end else if (wrEn) begin
      for (int p = 0; p < NUM_PADS; p++) begin
        if (wrAddr == ADDR_W'(p / FPW))
          selQ[p] <= wrData[(p % FPW)*SEL_W +: SEL_W];
        if (wrAddr == ADDR_W'(SEL_WORDS + p / DATA_W))
          dirQ[p] <= wrData[p % DATA_W];
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (rdAddr == ADDR_W'(p / FPW))
        rdData[(p % FPW)*SEL_W +: SEL_W] = selQ[p];
      if (rdAddr == ADDR_W'(SEL_WORDS + p / DATA_W))
        rdData[p % DATA_W] = dirQ[p];
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PADS; p++) begin
      cfg[p].sel     = fnSel_e'(selQ[p]);
      cfg[p].gpioDir = dirQ[p];
    end
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_chk
    localparam int SW = p / FPW;
    localparam int SB = (p % FPW) * SEL_W;
    localparam int DW = SEL_WORDS + p / DATA_W;
    localparam int DB = p % DATA_W;

    // R2: a selection write lands in the addressed field
    a_r2_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && wrAddr == ADDR_W'(SW)) |=> selQ[p] == $past(wrData[SB +: SEL_W]));

    // R2: a direction write lands in the addressed bit
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && wrAddr == ADDR_W'(DW)) |=> dirQ[p] == $past(wrData[DB]));

    // R3: no strobe, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wrEn |=> ($stable(selQ[p]) && $stable(dirQ[p])));
  end
endmodule

// File: rtl/pinmux_inmux.sv
module pinmux_inmux #(
  parameter int NUM_PADS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] req,
  input  logic [NUM_PADS-1:0] padIn,
  output logic                val
);
  logic [NUM_PADS-1:0] grant;

  // isolate the lowest requesting pad
  assign grant = req & (~req + NUM_PADS'(1));
  assign val   = |(grant & padIn);

  // R9 / R10: at most one pad feeds a line
  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9 / R10: a high value must come from a requesting pad that is high
  a_r10_val_source: assert property (@(posedge clk) disable iff (!rst_n)
    val |-> |(req & padIn));
endmodule

// File: rtl/pinmux_datapath.sv
module pinmux_datapath
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int NUM_BUS  = 2,
  parameter int NUM_EMIT = 2,
  parameter int NUM_CAPT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  padCfg_t             cfg [NUM_PADS],
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOe,
  input  logic [NUM_PADS-1:0] gpioOut,
  output logic [NUM_PADS-1:0] gpioIn,
  input  logic [NUM_BUS-1:0]  busOut,
  input  logic [NUM_BUS-1:0]  busOe,
  output logic [NUM_BUS-1:0]  busIn,
  input  logic [NUM_EMIT-1:0] emitOut,
  output logic [NUM_CAPT-1:0] captIn
);
  // Output side: one mux per pad
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    always_comb begin
      padOut[p] = 1'b0;
      padOe[p]  = 1'b0;
      unique case (cfg[p].sel)
        FN_GPIO: begin padOut[p] = gpioOut[p];            padOe[p] = cfg[p].gpioDir;      end
        FN_BUS:  begin padOut[p] = busOut[p % NUM_BUS];   padOe[p] = busOe[p % NUM_BUS];  end
        FN_EMIT: begin padOut[p] = emitOut[p % NUM_EMIT]; padOe[p] = 1'b1;                end
        FN_CAPT: begin padOut[p] = 1'b0;                  padOe[p] = 1'b0;                end
        default: ;
      endcase
    end

    // 1:1 line: a single AND gate
    assign gpioIn[p] = padIn[p] & (cfg[p].sel == FN_GPIO);

    a_r5_gpio_gate: assert property (@(posedge clk) disable iff (!rst_n)
      gpioIn[p] |-> (cfg[p].sel == FN_GPIO && padIn[p]));
    a_r7_emit_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[p].sel == FN_EMIT) |-> padOe[p]);
    a_r8_capt_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[p].sel == FN_CAPT) |-> (!padOe[p] && !padOut[p]));
  end

  // Input side: priority mux per bus line
  for (genvar k = 0; k < NUM_BUS; k++) begin : g_busIn
    logic [NUM_PADS-1:0] req;
    always_comb
      for (int p = 0; p < NUM_PADS; p++)
        req[p] = (cfg[p].sel == FN_BUS) && (p % NUM_BUS == k);
    pinmux_inmux #(.NUM_PADS(NUM_PADS)) u_mux (
      .clk(clk), .rst_n(rst_n), .req(req), .padIn(padIn), .val(busIn[k]));
  end

  // Input side: priority mux per capture line (output-only slot gets none)
  for (genvar k = 0; k < NUM_CAPT; k++) begin : g_captIn
    logic [NUM_PADS-1:0] req;
    always_comb
      for (int p = 0; p < NUM_PADS; p++)
        req[p] = (cfg[p].sel == FN_CAPT) && (p % NUM_CAPT == k);
    pinmux_inmux #(.NUM_PADS(NUM_PADS)) u_mux (
      .clk(clk), .rst_n(rst_n), .req(req), .padIn(padIn), .val(captIn[k]));
  end
endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int NUM_BUS  = 2,
  parameter int NUM_EMIT = 2,
  parameter int NUM_CAPT = 3,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = $clog2((NUM_PADS + DATA_W/SEL_W - 1) / (DATA_W/SEL_W)
                                  + (NUM_PADS + DATA_W - 1) / DATA_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOe,
  input  logic [NUM_PADS-1:0] gpioOut,
  output logic [NUM_PADS-1:0] gpioIn,
  input  logic [NUM_BUS-1:0]  busOut,
  input  logic [NUM_BUS-1:0]  busOe,
  output logic [NUM_BUS-1:0]  busIn,
  input  logic [NUM_EMIT-1:0] emitOut,
  output logic [NUM_CAPT-1:0] captIn
);
  padCfg_t cfg [NUM_PADS];

  pinmux_ctrl #(.NUM_PADS(NUM_PADS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cfg(cfg));

  pinmux_datapath #(.NUM_PADS(NUM_PADS), .NUM_BUS(NUM_BUS), .NUM_EMIT(NUM_EMIT),
                    .NUM_CAPT(NUM_CAPT)) u_dp (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .gpioOut(gpioOut), .gpioIn(gpioIn), .busOut(busOut),
    .busOe(busOe), .busIn(busIn), .emitOut(emitOut), .captIn(captIn));
endmodule

// File: tb/pinmux_top_tb_top.sv
`timescale 1ns/1ps
module pinmux_top_tb_top;
  localparam int NP = 8, NB = 2, NE = 2, NC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, rdData;
  logic [NP-1:0] padIn = '0, padOut, padOe, gpioOut = '0, gpioIn;
  logic [NB-1:0] busOut = '0, busOe = '0, busIn;
  logic [NE-1:0] emitOut = '0;
  logic [NC-1:0] captIn;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  logic [1:0] shSel [NP];
  logic [NP-1:0] shDir;

  always #10 clk = ~clk;

  pinmux_top dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .gpioOut(gpioOut), .gpioIn(gpioIn), .busOut(busOut), .busOe(busOe), .busIn(busIn),
    .emitOut(emitOut), .captIn(captIn));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic applyCfg();
    writeReg(2'd0, {shSel[3], shSel[2], shSel[1], shSel[0]});
    writeReg(2'd1, {shSel[7], shSel[6], shSel[5], shSel[4]});
    writeReg(2'd2, shDir);
  endtask

  task automatic setAll(input logic [1:0] s, input logic [NP-1:0] d);
    for (int p = 0; p < NP; p++) shSel[p] = s;
    shDir = d;
    applyCfg();
  endtask

  // Reference model of the requirements, compared at the ports
  task automatic checkAll(input string tag);
    logic [NP-1:0] eOut, eOe, eGpio;
    logic [NB-1:0] eBus;
    logic [NC-1:0] eCapt;
    bit [NB-1:0] bSeen;
    bit [NC-1:0] cSeen;
    #1;
    eBus = '0; eCapt = '0; bSeen = '0; cSeen = '0;
    for (int p = 0; p < NP; p++) begin
      case (shSel[p])
        2'd0: begin eOut[p] = gpioOut[p];     eOe[p] = shDir[p];       end
        2'd1: begin eOut[p] = busOut[p % NB]; eOe[p] = busOe[p % NB];  end
        2'd2: begin eOut[p] = emitOut[p % NE]; eOe[p] = 1'b1;          end
        default: begin eOut[p] = 1'b0;        eOe[p] = 1'b0;           end
      endcase
      eGpio[p] = padIn[p] & (shSel[p] == 2'd0);
      if (shSel[p] == 2'd1 && !bSeen[p % NB]) begin bSeen[p % NB] = 1'b1; eBus[p % NB] = padIn[p]; end
      if (shSel[p] == 2'd3 && !cSeen[p % NC]) begin cSeen[p % NC] = 1'b1; eCapt[p % NC] = padIn[p]; end
    end
    check(padOut == eOut, {tag, " padOut"}, 32'(padOut), 32'(eOut));
    check(padOe == eOe, {tag, " padOe"}, 32'(padOe), 32'(eOe));
    check(gpioIn == eGpio, {tag, " gpioIn"}, 32'(gpioIn), 32'(eGpio));
    check(busIn == eBus, {tag, " busIn"}, 32'(busIn), 32'(eBus));
    check(captIn == eCapt, {tag, " captIn"}, 32'(captIn), 32'(eCapt));
  endtask

  task automatic readCheck(input logic [1:0] a, input logic [7:0] exp, input string tag);
    rdAddr = a; #1;
    check(rdData == exp, tag, 32'(rdData), 32'(exp));
  endtask

  task automatic t_reset();
    for (int p = 0; p < NP; p++) shSel[p] = 2'd0;
    shDir = '0;
    gpioOut = 8'h5A; padIn = 8'hC3;
    checkAll("R1");
    check(padOe == '0, "R1 padOe", 32'(padOe), 0);
    for (int a = 0; a < 3; a++) readCheck(2'(a), 8'h00, "R1 read");
  endtask

  task automatic t_regs();
    writeReg(2'd0, 8'hE4); readCheck(2'd0, 8'hE4, "R2 sel word0");
    writeReg(2'd1, 8'h1B); readCheck(2'd1, 8'h1B, "R2 sel word1");
    writeReg(2'd2, 8'hA5); readCheck(2'd2, 8'hA5, "R2 dir word");
    writeReg(2'd3, 8'hFF);
    readCheck(2'd3, 8'h00, "R3 unmapped read");
    readCheck(2'd0, 8'hE4, "R3 unmapped write word0");
    readCheck(2'd1, 8'h1B, "R3 unmapped write word1");
    readCheck(2'd2, 8'hA5, "R3 unmapped write dir");
    @(negedge clk); wrAddr = 2'd0; wrData = 8'h00;
    @(negedge clk);
    readCheck(2'd0, 8'hE4, "R3 no strobe");
    // keep shadow in step: 0xE4 -> pads0..3 = 0,1,2,3 ; 0x1B -> pads4..7 = 3,2,1,0
    shSel[0] = 0; shSel[1] = 1; shSel[2] = 2; shSel[3] = 3;
    shSel[4] = 3; shSel[5] = 2; shSel[6] = 1; shSel[7] = 0;
    shDir = 8'hA5;
    checkAll("R2 mixed");
  endtask

  task automatic t_gpio();
    setAll(2'd0, 8'h0F);
    gpioOut = 8'hAA; padIn = 8'h55; checkAll("R4");
    gpioOut = 8'h55; padIn = 8'hAA; checkAll("R5");
    check(gpioIn == 8'hAA, "R5 gate", 32'(gpioIn), 32'hAA);
  endtask

  task automatic t_bus();
    setAll(2'd1, 8'h00);
    busOut = 2'b01; busOe = 2'b10; padIn = 8'h01; checkAll("R6");
    check(padOut == 8'h55 && padOe == 8'hAA, "R6 pattern", {padOut, padOe}, 32'h55AA);
    check(busIn == 2'b01, "R9 lowest pad", 32'(busIn), 1);
    check(gpioIn == '0, "R5 unselected", 32'(gpioIn), 0);
    padIn = 8'hFC; checkAll("R9 high pads only");
    check(busIn == 2'b00, "R9 pads0/1 low win", 32'(busIn), 0);
  endtask

  task automatic t_emit();
    setAll(2'd2, 8'h00);
    emitOut = 2'b10; checkAll("R7");
    check(padOe == 8'hFF && padOut == 8'hAA, "R7 pattern", {padOut, padOe}, 32'hAAFF);
  endtask

  task automatic t_capt();
    setAll(2'd3, 8'hFF);
    padIn = 8'hFF; gpioOut = 8'hFF; checkAll("R8");
    check(padOe == '0, "R8 no drive", 32'(padOe), 0);
    // only pads 2 and 5 on capture line 2
    for (int p = 0; p < NP; p++) shSel[p] = 2'd0;
    shSel[2] = 2'd3; shSel[5] = 2'd3; shDir = '0;
    applyCfg();
    padIn = 8'b0010_0000; checkAll("R10 pair");
    check(captIn == 3'b000, "R10 pad2 wins", 32'(captIn), 0);
    shSel[2] = 2'd0; applyCfg();
    checkAll("R10 pad5 alone");
    check(captIn == 3'b100, "R10 pad5", 32'(captIn), 4);
    shSel[5] = 2'd1; applyCfg();
    check(captIn == 3'b000, "R10 none", 32'(captIn), 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      for (int p = 0; p < NP; p++) shSel[p] = 2'($urandom_range(0, 3));
      shDir = 8'($urandom);
      applyCfg();
      for (int j = 0; j < 3; j++) begin
        padIn = 8'($urandom); gpioOut = 8'($urandom);
        busOut = 2'($urandom); busOe = 2'($urandom); emitOut = 2'($urandom);
        checkAll("R9/R10 random");
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gpio();
    t_bus();
    t_emit();
    t_capt();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule